// File: doc/BRIEF.md
# Read Data Valid Timing Chain

This block tells the read side of a quad-data-rate SRAM controller which returning half-clock beats carry read data. Each read strobe the controller issues is fed into a short history register. A stage-select picks the taps whose distance matches the configured read latency of 1.5, 2 or 2.5 clocks and the configured burst of 2 or 4 beats. The selected taps give a per-beat valid. Time is counted in half-clock steps: every clock carries two phase bits, one for the rising-edge beat and one for the falling-edge beat. This means odd half-cycle latencies come out exactly.

In its second mode the block ignores the issued strobes and uses a valid pin driven by the memory itself. That pin leads the data by half a clock, so the block delays it by one half-clock stage to line it up with the beats. In both modes the valid beats also steer a small assembler. The assembler pairs consecutive valid beats into one word of twice the SRAM width and hands it to user logic with a one-clock strobe.

Top module: `rdv_timing_chain`

## Requirements
- R1: Latency code `cfgLatency` selects H half-steps: 0 gives 3 (1.5 clocks), 1 gives 4 (2 clocks), 2 and 3 give 5 (2.5 clocks). A read sampled on `rdIssue` at clock edge k makes its first valid beat at half-step 2k+H. After edge e, `beatValid[0]` describes half-step 2e and `beatValid[1]` describes half-step 2e+1.
- R2: With `cfgBurst4`=0 a read yields exactly 2 consecutive valid beats; with `cfgBurst4`=1 it yields exactly 4.
- R3: With latency code 1, both beats of any clock are either valid together or invalid together.
- R4: Back-to-back reads give an unbroken run of valid beats with no gap between bursts. This holds for reads issued every clock with 2-beat bursts and every other clock with 4-beat bursts.
- R5: With `cfgUseMemValid`=0, no beat is valid unless a read was issued within the latency-plus-burst window, and the `memValid` pin has no effect.
- R6: With `cfgUseMemValid`=1, `memValid[0]` and `memValid[1]` sampled at edge e stand for half-steps 2e and 2e+1. Each pin beat reappears on `beatValid` one half-step later. `rdIssue` has no effect in this mode.
- R7: `qBeats` sampled at edge e+1 carries the data of half-steps 2e (low `DATA_W` bits) and 2e+1 (high bits). Every two consecutive valid beats form one word, with the earlier beat in the low half. The word appears on `rdWord` with `rdWordValid` high for one clock, after the edge that samples the second beat.
- R8: `rdWordValid` stays low in any clock where no word completes.
- R9: Reset clears the history chain, the half-step register, any half-assembled word and all outputs. A read issued before or during reset never produces a valid beat afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgLatency | input | 2 | Read latency code (R1) |
| cfgBurst4 | input | 1 | 1 = 4-beat burst, 0 = 2-beat burst |
| cfgUseMemValid | input | 1 | 1 = use the memory valid pin instead of the chain |
| rdIssue | input | 1 | Read strobe issued to the SRAM this clock |
| memValid | input | 2 | Memory valid pin, bit 0 rising beat, bit 1 falling beat |
| qBeats | input | 2*DATA_W | Captured read data, two beats per clock |
| beatValid | output | 2 | Per-beat valid, bit 0 rising beat, bit 1 falling beat |
| rdWord | output | 2*DATA_W | Assembled read word |
| rdWordValid | output | 1 | One-clock strobe marking a new `rdWord` |

## Verification
The assertions check several rules on every cycle:
- no valid beat appears in chain mode while the issue history is empty;
- beats come in pairs at the 2-clock latency;
- in pin mode, the falling beat follows the pin's rising beat half a clock later;
- no word is strobed without a valid beat;
- the outputs are clear on leaving reset.

Some behaviour only the directed scenarios can show. These are the exact start half-step for each latency code, the burst length, and gapless back-to-back runs. They also include word pairing across a clock boundary at odd latencies, and the loss of a read that was in flight when reset arrived.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

  // Valid strobes for the two half-clock beats of one clock.
  typedef struct packed {
    logic lo;  // rising-edge beat
    logic hi;  // falling-edge beat
  } beatStrb_t;

  // Latency code to half-step count.
  function automatic int unsigned latHalfSteps(input logic [1:0] code);
    case (code)
      2'd0:    return 3;
      2'd1:    return 4;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/rdv_chain_ctrl.sv
module rdv_chain_ctrl
  import rdv_pkg::*;
#(
  parameter int MAX_LAT_HALF = 5,
  parameter int MAX_BURST    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgLatency,
  input  logic       cfgBurst4,
  input  logic       cfgUseMemValid,
  input  logic       rdIssue,
  input  logic [1:0] memValid,
  output logic [1:0] beatValid,
  output beatStrb_t  strb
);

  localparam int HIST_DEPTH = (MAX_LAT_HALF + MAX_BURST - 1) / 2;
  localparam int CNT_W      = $clog2(2 * HIST_DEPTH + MAX_BURST + 2) + 1;

  logic [HIST_DEPTH-1:0] issHist;
  logic [HIST_DEPTH-1:0] hitLo;
  logic [HIST_DEPTH-1:0] hitHi;
  logic [CNT_W-1:0]      latHalf;
  logic [CNT_W-1:0]      winEnd;
  logic [1:0]            chainNext;
  logic [1:0]            memNext;
  logic                  memHiQ;

  assign latHalf = CNT_W'(latHalfSteps(cfgLatency));
  assign winEnd  = latHalf + (cfgBurst4 ? CNT_W'(4) : CNT_W'(2));

  // Issue history: stage i holds the read sampled i+1 edges before the next one.
  always_ff @(posedge clk) begin
    if (!rstN) issHist <= '0;
    else       issHist <= {issHist[HIST_DEPTH-2:0], rdIssue & ~cfgUseMemValid};
  end

  // Each stage/phase sits a fixed half-step distance from its issue.
  for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_tap
    localparam logic [CNT_W-1:0] DIST_LO = CNT_W'(2 * (i + 1));
    localparam logic [CNT_W-1:0] DIST_HI = CNT_W'(2 * (i + 1) + 1);
    assign hitLo[i] = issHist[i] && (DIST_LO >= latHalf) && (DIST_LO < winEnd);
    assign hitHi[i] = issHist[i] && (DIST_HI >= latHalf) && (DIST_HI < winEnd);
  end

  assign chainNext = {|hitHi, |hitLo};
  // Pin path: one half-step of delay.
  assign memNext   = {memValid[0], memHiQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memHiQ    <= 1'b0;
      beatValid <= 2'b00;
    end else begin
      memHiQ    <= memValid[1];
      beatValid <= cfgUseMemValid ? memNext : chainNext;
    end
  end

  assign strb.lo = beatValid[0];
  assign strb.hi = beatValid[1];

  // R5: empty history in chain mode gives no valid beat
  a_r5_no_issue_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgUseMemValid && issHist == '0) |=> (beatValid == 2'b00));

  // R3: two-clock latency keeps beats paired inside one clock
  a_r3_paired_beats: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgUseMemValid && cfgLatency == 2'd1) |=> (beatValid[0] == beatValid[1]));

  // R6: pin rising beat shows up half a clock later
  a_r6_pin_half_delay: assert property (@(posedge clk) disable iff (!rstN)
    cfgUseMemValid |=> (beatValid[1] == $past(memValid[0])));

  // R9: nothing valid on leaving reset
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (beatValid == 2'b00));

endmodule

// File: rtl/rdv_word_dp.sv
module rdv_word_dp
  import rdv_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  beatStrb_t             strb,
  input  logic [2*DATA_W-1:0]   qBeats,
  output logic [2*DATA_W-1:0]   rdWord,
  output logic                  rdWordValid
);

  logic [DATA_W-1:0]   beatLo;
  logic [DATA_W-1:0]   beatHi;
  logic                pendValid;
  logic [DATA_W-1:0]   pendData;
  logic                nextPendValid;
  logic [DATA_W-1:0]   nextPendData;
  logic                nextWordValid;
  logic [2*DATA_W-1:0] nextWord;

  assign beatLo = qBeats[DATA_W-1:0];
  assign beatHi = qBeats[2*DATA_W-1:DATA_W];

  always_comb begin
    nextPendValid = pendValid;
    nextPendData  = pendData;
    nextWordValid = 1'b0;
    nextWord      = rdWord;
    case ({strb.hi, strb.lo})
      2'b11: begin
        nextWordValid = 1'b1;
        if (pendValid) begin
          nextWord     = {beatLo, pendData};
          nextPendData = beatHi;
        end else begin
          nextWord = {beatHi, beatLo};
        end
      end
      2'b01: begin
        if (pendValid) begin
          nextWordValid = 1'b1;
          nextWord      = {beatLo, pendData};
          nextPendValid = 1'b0;
        end else begin
          nextPendValid = 1'b1;
          nextPendData  = beatLo;
        end
      end
      2'b10: begin
        if (pendValid) begin
          nextWordValid = 1'b1;
          nextWord      = {beatHi, pendData};
          nextPendValid = 1'b0;
        end else begin
          nextPendValid = 1'b1;
          nextPendData  = beatHi;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendData    <= '0;
      rdWord      <= '0;
      rdWordValid <= 1'b0;
    end else begin
      pendValid   <= nextPendValid;
      pendData    <= nextPendData;
      rdWord      <= nextWord;
      rdWordValid <= nextWordValid;
    end
  end

  // R8: a word needs at least one valid beat in the clock before it
  a_r8_no_word_without_beat: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lo && !strb.hi) |=> !rdWordValid);

endmodule

// File: rtl/rdv_timing_chain.sv
module rdv_timing_chain
  import rdv_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter int MAX_LAT_HALF = 5,
  parameter int MAX_BURST    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgLatency,
  input  logic                cfgBurst4,
  input  logic                cfgUseMemValid,
  input  logic                rdIssue,
  input  logic [1:0]          memValid,
  input  logic [2*DATA_W-1:0] qBeats,
  output logic [1:0]          beatValid,
  output logic [2*DATA_W-1:0] rdWord,
  output logic                rdWordValid
);

  beatStrb_t strb;

  rdv_chain_ctrl #(
    .MAX_LAT_HALF (MAX_LAT_HALF),
    .MAX_BURST    (MAX_BURST)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgLatency     (cfgLatency),
    .cfgBurst4      (cfgBurst4),
    .cfgUseMemValid (cfgUseMemValid),
    .rdIssue        (rdIssue),
    .memValid       (memValid),
    .beatValid      (beatValid),
    .strb           (strb)
  );

  rdv_word_dp #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .qBeats      (qBeats),
    .rdWord      (rdWord),
    .rdWordValid (rdWordValid)
  );

endmodule

// File: tb/rdv_timing_chain_tb_top.sv
`timescale 1ns/1ps
module rdv_timing_chain_tb_top;

  localparam int DW   = 18;
  localparam int NCYC = 28;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cfgLatency = 2'd0;
  logic          cfgBurst4 = 1'b0;
  logic          cfgUseMemValid = 1'b0;
  logic          rdIssue = 1'b0;
  logic [1:0]    memValid = 2'b00;
  logic [2*DW-1:0] qBeats = '0;
  logic [1:0]    beatValid;
  logic [2*DW-1:0] rdWord;
  logic          rdWordValid;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  bit              expHalf [0:127];
  bit              expWv   [0:63];
  logic [2*DW-1:0] expWd   [0:63];

  always #2 clk = ~clk;

  rdv_timing_chain #(.DATA_W(DW)) dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .cfgLatency     (cfgLatency),
    .cfgBurst4      (cfgBurst4),
    .cfgUseMemValid (cfgUseMemValid),
    .rdIssue        (rdIssue),
    .memValid       (memValid),
    .qBeats         (qBeats),
    .beatValid      (beatValid),
    .rdWord         (rdWord),
    .rdWordValid    (rdWordValid)
  );

  function automatic logic [DW-1:0] beatData(input int h);
    return DW'((h * 1237 + 91) ^ 18'h2A5A5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic applyReset(input logic [1:0] lat, input logic b4, input logic um);
    @(negedge clk);
    rstN = 1'b0; rdIssue = 1'b0; memValid = 2'b00; qBeats = '0;
    cfgLatency = lat; cfgBurst4 = b4; cfgUseMemValid = um;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Run NCYC clocks after reset; edge c samples issPat[c] and memPat[2c+1:2c].
  task automatic runScenario(input string req, input logic [1:0] lat, input logic b4,
                             input logic um, input logic [31:0] issPat,
                             input logic [63:0] memPat);
    int hLat;
    int nBeats;
    bit pend;
    int pendH;
    hLat   = (lat == 2'd0) ? 3 : (lat == 2'd1) ? 4 : 5;
    nBeats = b4 ? 4 : 2;
    for (int i = 0; i < 128; i++) expHalf[i] = 1'b0;
    for (int i = 0; i < 64; i++) begin expWv[i] = 1'b0; expWd[i] = '0; end
    if (!um) begin
      for (int c = 0; c < NCYC; c++)
        if (issPat[c])
          for (int b = 0; b < nBeats; b++) expHalf[2*c + hLat + b] = 1'b1;
    end else begin
      for (int h = 0; h < 2*NCYC; h++)
        if (memPat[h]) expHalf[h+1] = 1'b1;
    end
    pend = 1'b0; pendH = 0;
    for (int h = 0; h < 2*NCYC; h++) begin
      if (expHalf[h]) begin
        if (pend) begin
          expWv[h/2 + 1] = 1'b1;
          expWd[h/2 + 1] = {beatData(h), beatData(pendH)};
          pend = 1'b0;
        end else begin
          pend = 1'b1; pendH = h;
        end
      end
    end
    applyReset(lat, b4, um);
    // rstN released at this negedge; next posedge is edge 0
    for (int c = 0; c <= NCYC; c++) begin
      if (c > 0) begin
        chk(beatValid == {expHalf[2*(c-1)+1], expHalf[2*(c-1)]}, req, "beatValid",
            64'(beatValid), 64'({expHalf[2*(c-1)+1], expHalf[2*(c-1)]}));
        chk(rdWordValid == expWv[c-1], req, "rdWordValid",
            64'(rdWordValid), 64'(expWv[c-1]));
        if (expWv[c-1])
          chk(rdWord == expWd[c-1], req, "rdWord", 64'(rdWord), 64'(expWd[c-1]));
      end
      if (c < NCYC) begin
        rdIssue  = issPat[c];
        memValid = {memPat[2*c+1], memPat[2*c]};
        qBeats   = (c > 0) ? {beatData(2*c-1), beatData(2*c-2)} : '0;
        @(negedge clk);
      end
    end
    rdIssue = 1'b0; memValid = 2'b00;
  endtask

  // R9: reset holds outputs clear even with active stimulus
  task automatic testResetState();
    @(negedge clk);
    rstN = 1'b0; cfgLatency = 2'd0; cfgBurst4 = 1'b1; cfgUseMemValid = 1'b0;
    rdIssue = 1'b1; memValid = 2'b11;
    repeat (6) @(negedge clk);
    chk(beatValid == 2'b00, "R9", "beatValid in reset", 64'(beatValid), 64'd0);
    chk(rdWordValid == 1'b0, "R9", "rdWordValid in reset", 64'(rdWordValid), 64'd0);
    rdIssue = 1'b0; memValid = 2'b00;
  endtask

  // R9: a read in flight when reset arrives is dropped
  task automatic testMidReset();
    applyReset(2'd2, 1'b1, 1'b0);
    rdIssue = 1'b1;
    @(negedge clk);
    rdIssue = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(beatValid == 2'b00, "R9", "beatValid after reset", 64'(beatValid), 64'd0);
      chk(rdWordValid == 1'b0, "R9", "rdWordValid after reset", 64'(rdWordValid), 64'd0);
    end
  endtask

  initial begin
    testResetState();
    runScenario("R1 R2 R7 lat1.5",      2'd0, 1'b0, 1'b0, 32'h0000_0004, 64'h0);
    runScenario("R1 R3 lat2",           2'd1, 1'b0, 1'b0, 32'h0000_0008, 64'h0);
    runScenario("R1 R2 R7 lat2.5 b4",   2'd2, 1'b1, 1'b0, 32'h0000_0004, 64'h0);
    runScenario("R1 code3",             2'd3, 1'b0, 1'b0, 32'h0000_0002, 64'h0);
    runScenario("R3 R2 lat2 b4",        2'd1, 1'b1, 1'b0, 32'h0000_0024, 64'h0);
    runScenario("R4 R7 b2 every clock", 2'd0, 1'b0, 1'b0, 32'h0000_00FC, 64'h0);
    runScenario("R4 b4 every other",    2'd2, 1'b1, 1'b0, 32'h0000_0154, 64'h0);
    runScenario("R5 pin ignored",       2'd1, 1'b0, 1'b0, 32'h0000_0010,
                64'hF0F0_3C3C_A5A5_0FF0);
    runScenario("R6 R7 pin mode",       2'd0, 1'b0, 1'b1, 32'h0000_FFFF,
                64'h0000_0018_0003_3C00);
    runScenario("R5 R8 idle",           2'd1, 1'b1, 1'b0, 32'h0, 64'h0);
    testMidReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule